// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind a receive deframer that has already stripped flags and removed stuffed zeros. It watches the byte stream of each frame, compares the leading address byte or bytes against programmed and fixed values, and registers one verdict per frame. The verdict says whether the frame is kept and which address pairing matched. It also says whether the frame belongs to the single logical link that the controller answers on its own, and what the command/response bit carried.

The filter handles one-byte and two-byte address fields. In two-byte mode the high byte is checked against two programmable values and the two fixed group values, and the low byte against two programmable values. Optionally, the command/response bit of the high byte can be left out of the comparison and reported on its own. In one-byte mode the two low-byte values stand for command and response. When a frame of the autonomously handled link ends, a response-start request fires a fixed number of cycles later.

The configuration inputs are captured when a frame begins. Software may therefore rewrite them while a frame is still arriving.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_done`, `res_hit`, `res_combo`, `res_auto`, `res_cr` and `resp_start` are all zero.
- R2: With `cfg_two_byte`=1, a frame is accepted when its first byte equals `cmp_hi_a` (class 0), `cmp_hi_b` (class 1) or one of 0xFE/0xFC (class 2), and its second byte equals `cmp_lo_a` (class 0) or `cmp_lo_b` (class 1). Lower classes take priority. `res_combo` = 2*high class + low class, giving 0 to 5.
- R3: With `cfg_two_byte`=1 and `cfg_cr_en`=1, bit 1 of the high byte is ignored in every high-byte comparison and is reported on `res_cr`. With `cfg_cr_en`=0 that bit is compared like the others and `res_cr` is 0.
- R4: With `cfg_two_byte`=0, only the first byte is compared, against `cmp_lo_a` and `cmp_lo_b`. A match on `cmp_lo_a` gives `res_combo`=0 and `res_cr`=0 (command). A match only on `cmp_lo_b` gives `res_combo`=1 and `res_cr`=1 (response).
- R5: A frame whose address matches no allowed pairing gives `res_done`=1 with `res_hit`, `res_combo`, `res_auto` and `res_cr` all 0.
- R6: `res_auto` is 1 only for an accepted frame with `res_combo`=0 while the captured `cfg_mode` is 2'b00 (auto). Every other mode value, including 2'b01 (non-auto), gives 0.
- R7: When `frm_eof` ends a frame whose `res_auto` is 1, `resp_start` is high for exactly one cycle, the fifth cycle after the `frm_eof` cycle. No other frame end produces a pulse.
- R8: A frame that ends before all its address bytes have arrived (one in one-byte mode, two in two-byte mode) leaves `res_done` and `res_hit` at 0. Bytes after that end are ignored until the next `frm_sof`.
- R9: The results update in the cycle after the last address byte. They hold through later bytes and the frame end, and clear to zero in the cycle after the next `frm_sof`. `frm_sof` has priority over `frm_eof`, and `frm_eof` over a byte in the same cycle.
- R10: The compare values, `cfg_two_byte`, `cfg_cr_en` and `cfg_mode` are captured in the `frm_sof` cycle. Changing them later in a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_sof | input | 1 | Frame-start strobe |
| frm_eof | input | 1 | Frame-end strobe |
| byte_vld | input | 1 | Received byte valid |
| byte_data | input | 8 | Received byte |
| cfg_two_byte | input | 1 | 1: two-byte address, 0: one-byte address |
| cfg_cr_en | input | 1 | Exclude and report the command/response bit of the high byte |
| cfg_mode | input | 2 | Operating mode: 00 auto, 01 non-auto |
| cmp_hi_a | input | 8 | First programmable high-byte value |
| cmp_hi_b | input | 8 | Second programmable high-byte value |
| cmp_lo_a | input | 8 | First programmable low-byte value (command in one-byte mode) |
| cmp_lo_b | input | 8 | Second programmable low-byte value (response in one-byte mode) |
| res_done | output | 1 | Address evaluation complete for the current frame |
| res_hit | output | 1 | Frame accepted |
| res_combo | output | 3 | Index of the matched pairing |
| res_auto | output | 1 | Frame belongs to the autonomously handled link |
| res_cr | output | 1 | Extracted command/response indication |
| resp_start | output | 1 | Response-start request pulse |

## Verification
All state that matters shows up at the ports within one cycle. A stored high byte that is wrong or stale, or a configuration that was captured at the wrong time, gives a wrong `res_combo`, `res_cr` or `res_hit` in the cycle right after the second address byte. A lost frame-active flag or address-byte count shows up as `res_done` rising after a short frame, or as a result that changes when trailing bytes arrive. Faults in the response delay line show up within six cycles of the frame end, as a pulse that is missing, doubled or shifted. The bench compares all six outputs against a behavioural model on every cycle, so each of these faults is caught at its first visible cycle.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int BYTE_W  = 8;
  localparam int COMBO_W = 3;
  localparam int NUM_HI  = 4;   // hi_a, hi_b, two group values
  localparam int CR_POS  = 1;
  localparam logic [BYTE_W-1:0] GRP_VAL_A = 8'hFE;
  localparam logic [BYTE_W-1:0] GRP_VAL_B = 8'hFC;

  typedef enum logic [1:0] {
    MODE_AUTO   = 2'b00,
    MODE_MANUAL = 2'b01
  } af_mode_e;

  typedef struct packed {
    logic              two_byte;
    logic              cr_en;
    logic [1:0]        mode;
    logic [BYTE_W-1:0] hi_a;
    logic [BYTE_W-1:0] hi_b;
    logic [BYTE_W-1:0] lo_a;
    logic [BYTE_W-1:0] lo_b;
  } af_cfg_t;

  function automatic logic eq_masked(input logic [BYTE_W-1:0] a,
                                     input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] ign);
    return ((a ^ b) & ~ign) == '0;
  endfunction
endpackage

// File: rtl/af_cfg_latch.sv
module af_cfg_latch
  import hdlc_af_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  af_cfg_t cfg_d,
  output af_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (load) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/af_addr_match.sv
module af_addr_match
  import hdlc_af_pkg::*;
(
  input  af_cfg_t             cfg,
  input  logic [BYTE_W-1:0]   hi_byte,
  input  logic [BYTE_W-1:0]   lo_byte,
  output logic                hit,
  output logic [COMBO_W-1:0]  combo,
  output logic                auto_lnk,
  output logic                cr
);
  localparam logic [BYTE_W-1:0] CR_MASK = BYTE_W'(1) << CR_POS;

  logic [BYTE_W-1:0] hi_cand [NUM_HI];
  logic [BYTE_W-1:0] ign;
  logic [NUM_HI-1:0] hi_eq;
  logic [1:0]        lo_eq;
  logic              h_ok, l_ok;
  logic [1:0]        h_idx;
  logic              l_idx;

  assign ign     = cfg.cr_en ? CR_MASK : '0;
  assign hi_cand = '{cfg.hi_a, cfg.hi_b, GRP_VAL_A, GRP_VAL_B};

  for (genvar g = 0; g < NUM_HI; g++) begin : g_hi
    assign hi_eq[g] = eq_masked(hi_byte, hi_cand[g], ign);
  end
  assign lo_eq[0] = (lo_byte == cfg.lo_a);
  assign lo_eq[1] = (lo_byte == cfg.lo_b);

  always_comb begin
    h_ok  = |hi_eq;
    h_idx = hi_eq[0] ? 2'd0 : (hi_eq[1] ? 2'd1 : 2'd2);
    l_ok  = |lo_eq;
    l_idx = !lo_eq[0];
    if (cfg.two_byte) begin
      hit      = h_ok && l_ok;
      combo    = {h_idx, l_idx};
      cr       = cfg.cr_en && hi_byte[CR_POS];
      auto_lnk = hit && (h_idx == 2'd0) && !l_idx && (cfg.mode == MODE_AUTO);
    end else begin
      hit      = l_ok;
      combo    = {2'b00, l_idx};
      cr       = l_idx;
      auto_lnk = hit && !l_idx && (cfg.mode == MODE_AUTO);
    end
    if (!hit) begin
      combo    = '0;
      cr       = 1'b0;
      auto_lnk = 1'b0;
    end
  end
endmodule

// File: rtl/af_resp_delay.sv
module af_resp_delay #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  logic [DEPTH-1:0] stage;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) stage[s] <= rst ? 1'b0 : trig;
    end else begin : g_next
      always_ff @(posedge clk) stage[s] <= rst ? 1'b0 : stage[s-1];
    end
  end

  assign pulse = stage[DEPTH-1];
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int RESP_DELAY = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_sof,
  input  logic               frm_eof,
  input  logic               byte_vld,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic               cfg_two_byte,
  input  logic               cfg_cr_en,
  input  logic [1:0]         cfg_mode,
  input  logic [BYTE_W-1:0]  cmp_hi_a,
  input  logic [BYTE_W-1:0]  cmp_hi_b,
  input  logic [BYTE_W-1:0]  cmp_lo_a,
  input  logic [BYTE_W-1:0]  cmp_lo_b,
  output logic               res_done,
  output logic               res_hit,
  output logic [COMBO_W-1:0] res_combo,
  output logic               res_auto,
  output logic               res_cr,
  output logic               resp_start
);
  af_cfg_t           cfg_d, cfg_q;
  logic              active, have_hi;
  logic [BYTE_W-1:0] hi_q;
  logic              m_hit, m_auto, m_cr;
  logic [COMBO_W-1:0] m_combo;
  logic              resp_trig;

  assign cfg_d = '{two_byte: cfg_two_byte, cr_en: cfg_cr_en, mode: cfg_mode,
                   hi_a: cmp_hi_a, hi_b: cmp_hi_b, lo_a: cmp_lo_a, lo_b: cmp_lo_b};

  af_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .load(frm_sof), .cfg_d(cfg_d), .cfg_q(cfg_q)
  );

  af_addr_match u_match (
    .cfg(cfg_q), .hi_byte(hi_q), .lo_byte(byte_data),
    .hit(m_hit), .combo(m_combo), .auto_lnk(m_auto), .cr(m_cr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; have_hi <= 1'b0; hi_q <= '0;
      res_done <= 1'b0; res_hit <= 1'b0; res_combo <= '0;
      res_auto <= 1'b0; res_cr <= 1'b0;
    end else if (frm_sof) begin
      active <= 1'b1; have_hi <= 1'b0;
      res_done <= 1'b0; res_hit <= 1'b0; res_combo <= '0;
      res_auto <= 1'b0; res_cr <= 1'b0;
    end else if (frm_eof) begin
      active <= 1'b0;
    end else if (byte_vld && active && !res_done) begin
      if (cfg_q.two_byte && !have_hi) begin
        hi_q    <= byte_data;
        have_hi <= 1'b1;
      end else begin
        res_done  <= 1'b1;
        res_hit   <= m_hit;
        res_combo <= m_combo;
        res_auto  <= m_auto;
        res_cr    <= m_cr;
      end
    end
  end

  assign resp_trig = frm_eof && !frm_sof && active && res_done && res_auto;

  af_resp_delay #(.DEPTH(RESP_DELAY)) u_delay (
    .clk(clk), .rst(rst), .trig(resp_trig), .pulse(resp_start)
  );
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk
  import hdlc_af_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               frm_sof,
  input logic               res_done,
  input logic               res_hit,
  input logic [COMBO_W-1:0] res_combo,
  input logic               res_auto,
  input logic               res_cr,
  input logic               resp_start
);
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    frm_sof |=> !res_done && !res_hit && !res_auto); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_done && !frm_sof) |=> res_done && $stable({res_hit, res_combo, res_auto, res_cr})); // R9

  AST_COMBO_RANGE: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_combo <= 3'd5); // R2

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_combo == '0) && !res_auto && !res_cr); // R5

  AST_AUTO_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    res_auto |-> res_hit && (res_combo == '0)); // R6

  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    resp_start |=> !resp_start); // R7
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk chk_i (
  .clk(clk), .rst(rst), .frm_sof(frm_sof), .res_done(res_done),
  .res_hit(res_hit), .res_combo(res_combo), .res_auto(res_auto),
  .res_cr(res_cr), .resp_start(resp_start)
);

// File: tb/hdlc_addr_filter_tb_top.sv
`timescale 1ns/1ps
module hdlc_addr_filter_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, frm_sof = 0, frm_eof = 0, byte_vld = 0;
  logic [7:0] byte_data = 0;
  logic cfg_two_byte = 1, cfg_cr_en = 0;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] cmp_hi_a = 8'h30, cmp_hi_b = 8'h44, cmp_lo_a = 8'h01, cmp_lo_b = 8'h03;
  logic res_done, res_hit, res_auto, res_cr, resp_start;
  logic [2:0] res_combo;

  hdlc_addr_filter dut_i (.*);

  int total = 0, bad = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_active, m_have_hi, m_done, m_hit, m_auto, m_cr, m_resp;
  int m_combo;
  bit [7:0] m_hi;
  bit s_two, s_cr; int s_mode; bit [7:0] s_ha, s_hb, s_la, s_lb;
  longint edges = 0;
  longint pend[$];

  task automatic model_eval(input bit [7:0] lo);
    bit [7:0] cand[4];
    int cls[4];
    int hc, lc;
    bit [7:0] mask;
    cand = '{s_ha, s_hb, 8'hFE, 8'hFC};
    cls  = '{0, 1, 2, 2};
    hc = -1; lc = -1;
    mask = (s_two && s_cr) ? 8'hFD : 8'hFF;
    for (int i = 0; i < 4; i++)
      if (hc < 0 && ((m_hi & mask) == (cand[i] & mask))) hc = cls[i];
    if (lo == s_la) lc = 0; else if (lo == s_lb) lc = 1;
    if (s_two) begin
      m_hit = (hc >= 0) && (lc >= 0);
      m_combo = hc * 2 + lc;
      m_cr = s_cr ? m_hi[1] : 1'b0;
      m_auto = m_hit && s_mode == 0 && m_combo == 0;
    end else begin
      m_hit = lc >= 0;
      m_combo = lc;
      m_cr = (lc == 1);
      m_auto = m_hit && s_mode == 0 && lc == 0;
    end
    if (!m_hit) begin m_combo = 0; m_cr = 0; m_auto = 0; end
  endtask

  always @(posedge clk) begin
    edges++;
    if (rst) begin
      m_active = 0; m_have_hi = 0; m_done = 0; m_hit = 0; m_auto = 0;
      m_cr = 0; m_resp = 0; m_combo = 0; pend.delete();
    end else begin
      m_resp = (pend.size() > 0 && pend[0] == edges);
      if (m_resp) void'(pend.pop_front());
      if (frm_sof) begin
        s_two = cfg_two_byte; s_cr = cfg_cr_en; s_mode = cfg_mode;
        s_ha = cmp_hi_a; s_hb = cmp_hi_b; s_la = cmp_lo_a; s_lb = cmp_lo_b;
        m_active = 1; m_have_hi = 0; m_done = 0; m_hit = 0; m_combo = 0; m_auto = 0; m_cr = 0;
      end else if (frm_eof) begin
        if (m_active && m_done && m_auto) pend.push_back(edges + 4);
        m_active = 0;
      end else if (byte_vld && m_active && !m_done) begin
        if (s_two && !m_have_hi) begin m_hi = byte_data; m_have_hi = 1; end
        else begin m_done = 1; model_eval(byte_data); end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst)
      chk({res_done, res_hit, res_combo, res_auto, res_cr, resp_start} ==
          {m_done, m_hit, m_combo[2:0], m_auto, m_cr, m_resp}, cur_req, "model",
          {res_done, res_hit, res_combo, res_auto, res_cr, resp_start},
          {m_done, m_hit, m_combo[2:0], m_auto, m_cr, m_resp});
  end

  // ---------------- stimulus helpers ----------------
  task automatic p_sof();  frm_sof = 1; @(negedge clk); frm_sof = 0; endtask
  task automatic p_eof();  frm_eof = 1; @(negedge clk); frm_eof = 0; endtask
  task automatic p_byte(input logic [7:0] b);
    byte_vld = 1; byte_data = b; @(negedge clk); byte_vld = 0;
  endtask
  task automatic frame2(input logic [7:0] h, input logic [7:0] l);
    p_sof(); p_byte(h); p_byte(l);
  endtask
  task automatic exp_res(input string req, input bit d, input bit h, input int c, input bit a, input bit r);
    chk({res_done, res_hit, res_combo, res_auto, res_cr} == {d, h, c[2:0], a, r}, req, "result",
        {res_done, res_hit, res_combo, res_auto, res_cr}, {d, h, c[2:0], a, r});
  endtask
  task automatic eof_resp(input string req, input bit exp);
    p_eof();
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      chk(resp_start == (exp && k == 5), req, $sformatf("resp_start cycle %0d", k),
          resp_start, (exp && k == 5));
    end
  endtask

  initial begin
    #(50000 * 5);
    bad++; total++;
    $display("FAIL R7 watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    exp_res("R1", 0, 0, 0, 0, 0);
    chk(resp_start == 0, "R1", "resp_start", resp_start, 0);
    rst = 0;
    @(negedge clk);
    exp_res("R1", 0, 0, 0, 0, 0);

    cur_req = "R2";  // primary pair, auto mode
    frame2(8'h30, 8'h01); exp_res("R2", 1, 1, 0, 1, 0);
    cur_req = "R7"; eof_resp("R7", 1);
    cur_req = "R2";
    frame2(8'h44, 8'h03); exp_res("R2", 1, 1, 3, 0, 0); eof_resp("R7", 0);
    frame2(8'hFE, 8'h01); exp_res("R2", 1, 1, 4, 0, 0);
    frame2(8'hFC, 8'h03); exp_res("R2", 1, 1, 5, 0, 0);

    cur_req = "R5";
    frame2(8'h30, 8'h07); exp_res("R5", 1, 0, 0, 0, 0); eof_resp("R5", 0);
    frame2(8'h31, 8'h01); exp_res("R5", 1, 0, 0, 0, 0);

    cur_req = "R3"; cfg_cr_en = 1;
    frame2(8'h32, 8'h01); exp_res("R3", 1, 1, 0, 1, 1); eof_resp("R3", 1);
    frame2(8'hFE, 8'h03); exp_res("R3", 1, 1, 5, 0, 1);
    cfg_cr_en = 0;
    frame2(8'h32, 8'h01); exp_res("R3", 1, 0, 0, 0, 0);

    cur_req = "R4"; cfg_two_byte = 0;
    p_sof(); p_byte(8'h03); exp_res("R4", 1, 1, 1, 0, 1); eof_resp("R4", 0);
    p_sof(); p_byte(8'h01); exp_res("R4", 1, 1, 0, 1, 0); eof_resp("R7", 1);
    p_sof(); p_byte(8'h30); exp_res("R4", 1, 0, 0, 0, 0);
    cfg_two_byte = 1;

    cur_req = "R6"; cfg_mode = 2'b01;
    frame2(8'h30, 8'h01); exp_res("R6", 1, 1, 0, 0, 0); eof_resp("R6", 0);
    cfg_mode = 2'b10;
    frame2(8'h30, 8'h01); exp_res("R6", 1, 1, 0, 0, 0);
    cfg_mode = 2'b00;

    cur_req = "R8";
    p_sof(); p_byte(8'h30); p_eof(); exp_res("R8", 0, 0, 0, 0, 0);
    p_byte(8'h01); exp_res("R8", 0, 0, 0, 0, 0);
    p_sof(); p_eof(); p_byte(8'h30); p_byte(8'h01); exp_res("R8", 0, 0, 0, 0, 0);

    cur_req = "R9";
    frame2(8'h30, 8'h01);
    p_byte(8'h44); p_byte(8'h03); exp_res("R9", 1, 1, 0, 1, 0);
    p_eof(); exp_res("R9", 1, 1, 0, 1, 0);
    repeat (6) @(negedge clk);
    p_sof(); exp_res("R9", 0, 0, 0, 0, 0);
    frm_eof = 1; p_sof(); frm_eof = 0; exp_res("R9", 0, 0, 0, 0, 0);
    p_byte(8'h30); byte_vld = 1; byte_data = 8'h01; p_eof(); byte_vld = 0;
    exp_res("R9", 0, 0, 0, 0, 0);

    cur_req = "R10";
    p_sof(); cmp_lo_a = 8'h07; cfg_mode = 2'b01; cfg_two_byte = 0;
    p_byte(8'h30); p_byte(8'h01); exp_res("R10", 1, 1, 0, 1, 0);
    cur_req = "R7"; eof_resp("R7", 1);
    cmp_lo_a = 8'h01; cfg_mode = 2'b00; cfg_two_byte = 1;

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule